// File: doc/BRIEF.md
# Three-Channel Match/Overflow Timer

This block is a bus-mapped timer peripheral with three independent 32-bit counting channels. Each channel has a counter, a reload value and two compare values. It counts up or down, either on every peripheral clock or on rising edges of its own external tick input. A counter that runs past its end value is refilled from its reload value and raises an overflow event. A counter that steps onto either compare value raises a match event. Software can use these events for periodic ticks, for one-shot deadlines, or for a free-running time base.

One packed control word holds all channel settings. A status word collects the nine event flags, and each flag stays set until software clears it. A mask word shares the status bit layout. The status and mask words, together with the per-channel overflow-interrupt enables, drive a single interrupt line. The register bus has no wait states: a write takes effect at the clock edge on which `bus_we` is sampled high, and read data is a combinational function of `bus_addr`.

Top module: `tri_timer`

## Requirements
- R1: After a synchronous reset every register reads 0 and `irq` is low.
- R2: Channel n (0..2) has a counter at byte address 0x10·n, a reload value at 0x10·n+0x4, compare A at 0x10·n+0x8 and compare B at 0x10·n+0xC. The control word is at 0x30, the status word at 0x34 and the mask word at 0x38. Word-aligned registers read back what was written. Control keeps bits 11:0 and mask keeps bits 8:0; all other bits read as 0.
- R3: The control word gives channel n its enable at bit 3n. An enabled channel with clock select 0 counts on every clock edge. A disabled channel holds its counter.
- R4: Control bit 9+n set makes channel n count up. When that bit is clear, the channel counts down.
- R5: Counting up from 0xFFFFFFFF, or counting down from 0, loads the reload value into the counter and sets status bit 3n+2 (overflow).
- R6: A step that brings the counter to compare A sets status bit 3n. A step that brings it to compare B sets status bit 3n+1.
- R7: A bus write to a counter takes effect on that edge and overrides the counting step of that cycle.
- R8: With clock select (control bit 3n+1) set, channel n advances once per rising edge of `ext_tick[n]`. The input passes through two synchronising flops, so the counter changes on the third clock edge after the input rises.
- R9: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the bit set.
- R10: `irq` is high when some status bit is set and its mask bit is clear. An overflow bit counts only if that channel's overflow-interrupt enable (control bit 3n+2) is set. Match bits are gated only by the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_tick | input | 3 | Asynchronous external tick, one per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A control write that enables a channel lands on edge E0. The first count step follows on E1, and a disabling write on edge E(n+1) still performs one final step. An enable window of n idle cycles therefore yields exactly n+1 steps, and the bench predicts each counter value by applying the reload rule to that many steps. Status bits change on the same edge as the counter step that causes them. `irq` follows status, mask and control in the same cycle with no register in between, so the bench samples all of these at the falling edge after the write. For an external tick, the bench checks that the counter is unchanged after two edges and has advanced after the third.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int N_CH   = 3;
    localparam int ADDR_W = 6;
    localparam int EVT_W  = 3 * N_CH;
    localparam int CTRL_W = 4 * N_CH;
    localparam int SLOT_W = ADDR_W - 4;

    // shared slot following the channel slots
    localparam logic [SLOT_W-1:0] SHARED_SLOT = SLOT_W'(N_CH);

    typedef enum logic [1:0] {
        OFS_COUNT  = 2'd0,
        OFS_LOAD   = 2'd1,
        OFS_CMP_A  = 2'd2,
        OFS_CMP_B  = 2'd3
    } ch_ofs_e;

    typedef enum logic [1:0] {
        OFS_CTRL   = 2'd0,
        OFS_STATUS = 2'd1,
        OFS_MASK   = 2'd2,
        OFS_NONE   = 2'd3
    } sh_ofs_e;

    typedef struct packed {
        logic en;
        logic ext_sel;
        logic ovf_ie;
        logic up;
    } ch_ctrl_t;

    typedef struct packed {
        logic ovf;
        logic cmp_b;
        logic cmp_a;
    } ch_evt_t;

    function automatic ch_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w, input int ch);
        ch_ctrl_t c;
        c.en      = w[3*ch];
        c.ext_sel = w[3*ch+1];
        c.ovf_ie  = w[3*ch+2];
        c.up      = w[3*N_CH+ch];
        return c;
    endfunction
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tick_async,
    output logic [N-1:0] tick_rise
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= tick_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign tick_rise = sync_q & ~prev_q;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|tick_rise) |=> ((tick_rise & $past(tick_rise)) == '0)); // R8
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ch_ctrl_t     ctrl,
    input  logic         ext_rise,
    input  logic         wr_count,
    input  logic         wr_load,
    input  logic         wr_cmp_a,
    input  logic         wr_cmp_b,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic [W-1:0] cmp_a,
    output logic [W-1:0] cmp_b,
    output ch_evt_t      evt
);
    logic         advance;
    logic         step;
    logic         at_end;
    logic [W-1:0] nxt;

    always_comb begin
        advance = ctrl.en & (ctrl.ext_sel ? ext_rise : 1'b1);
        step    = advance & ~wr_count;
        if (ctrl.up) begin
            at_end = (count == '1);
            nxt    = at_end ? reload : count + W'(1);
        end else begin
            at_end = (count == '0);
            nxt    = at_end ? reload : count - W'(1);
        end
        evt.ovf   = step & at_end;
        evt.cmp_a = step & (nxt == cmp_a);
        evt.cmp_b = step & (nxt == cmp_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
            cmp_a  <= '0;
            cmp_b  <= '0;
        end else begin
            if (wr_count)  count <= wdata;
            else if (step) count <= nxt;
            if (wr_load)   reload <= wdata;
            if (wr_cmp_a)  cmp_a  <= wdata;
            if (wr_cmp_b)  cmp_b  <= wdata;
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !wr_count) |=> $stable(count)); // R3
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        evt.ovf |=> (count == $past(reload))); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_count |=> (count == $past(wdata))); // R7
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic [N_CH-1:0]  ovf_ie,
    input  logic             wr_status,
    input  logic             wr_mask,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] status,
    output logic [EVT_W-1:0] mask,
    output logic             irq
);
    logic [EVT_W-1:0] clr;
    logic [EVT_W-1:0] gate;

    assign clr = wr_status ? wdata : '0;

    for (genvar c = 0; c < N_CH; c++) begin : g_gate
        assign gate[3*c]   = 1'b1;
        assign gate[3*c+1] = 1'b1;
        assign gate[3*c+2] = ovf_ie[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr) | evt;
            if (wr_mask) mask <= wdata;
        end
    end

    assign irq = |(status & ~mask & gate);

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status) & ~$past(clr)) & ~status) == '0)); // R9
    AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status & $past(evt)) == $past(evt))); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((status & ~mask) == '0) |-> !irq); // R10
endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   ext_tick,
    output logic              irq
);
    logic              aligned;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        ofs;
    logic [CTRL_W-1:0] ctrl_q;
    logic [N_CH-1:0]   tick_rise;
    logic [N_CH-1:0]   ovf_ie;
    logic [EVT_W-1:0]  evt_all;
    logic [EVT_W-1:0]  status;
    logic [EVT_W-1:0]  mask;
    logic              sh_hit;

    logic [DATA_W-1:0] ch_count [N_CH];
    logic [DATA_W-1:0] ch_load  [N_CH];
    logic [DATA_W-1:0] ch_cmp_a [N_CH];
    logic [DATA_W-1:0] ch_cmp_b [N_CH];

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign slot    = bus_addr[ADDR_W-1:4];
    assign ofs     = bus_addr[3:2];
    assign sh_hit  = bus_we && aligned && (slot == SHARED_SLOT);

    always_ff @(posedge clk) begin
        if (rst)                               ctrl_q <= '0;
        else if (sh_hit && ofs == OFS_CTRL)    ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    tmr_tick_sync #(.N(N_CH)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .tick_async (ext_tick),
        .tick_rise  (tick_rise)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic     hit;
        ch_ctrl_t cc;
        ch_evt_t  ev;

        assign hit       = bus_we && aligned && (slot == SLOT_W'(c));
        assign cc        = unpack_ctrl(ctrl_q, c);
        assign ovf_ie[c] = cc.ovf_ie;
        assign evt_all[3*c+2:3*c] = ev;

        tmr_channel #(.W(DATA_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (cc),
            .ext_rise (tick_rise[c]),
            .wr_count (hit && ofs == OFS_COUNT),
            .wr_load  (hit && ofs == OFS_LOAD),
            .wr_cmp_a (hit && ofs == OFS_CMP_A),
            .wr_cmp_b (hit && ofs == OFS_CMP_B),
            .wdata    (bus_wdata),
            .count    (ch_count[c]),
            .reload   (ch_load[c]),
            .cmp_a    (ch_cmp_a[c]),
            .cmp_b    (ch_cmp_b[c]),
            .evt      (ev)
        );
    end

    tmr_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_all),
        .ovf_ie    (ovf_ie),
        .wr_status (sh_hit && ofs == OFS_STATUS),
        .wr_mask   (sh_hit && ofs == OFS_MASK),
        .wdata     (bus_wdata[EVT_W-1:0]),
        .status    (status),
        .mask      (mask),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int c = 0; c < N_CH; c++) begin
                if (slot == SLOT_W'(c)) begin
                    case (ofs)
                        OFS_COUNT: bus_rdata = ch_count[c];
                        OFS_LOAD:  bus_rdata = ch_load[c];
                        OFS_CMP_A: bus_rdata = ch_cmp_a[c];
                        default:   bus_rdata = ch_cmp_b[c];
                    endcase
                end
            end
            if (slot == SHARED_SLOT) begin
                case (ofs)
                    OFS_CTRL:   bus_rdata = DATA_W'(ctrl_q);
                    OFS_STATUS: bus_rdata = DATA_W'(status);
                    OFS_MASK:   bus_rdata = DATA_W'(mask);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0)); // R10
endmodule

// File: tb/tri_timer_bench.sv
`timescale 1ns/1ps
module tri_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ext_tick = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tri_timer u_tri_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] ld,
                                          input bit up, input int k, output bit wrapped);
        logic [31:0] v = c;
        wrapped = 0;
        for (int i = 0; i < k; i++) begin
            if (up) begin
                if (v == 32'hFFFF_FFFF) begin v = ld; wrapped = 1; end
                else v = v + 1;
            end else begin
                if (v == 0) begin v = ld; wrapped = 1; end
                else v = v - 1;
            end
        end
        return v;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp;
        bit wrapped;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        rd(6'h00, d); chk("R1 count0", d, 0);
        rd(6'h24, d); chk("R1 load2", d, 0);
        rd(6'h30, d); chk("R1 ctrl", d, 0);
        rd(6'h34, d); chk("R1 status", d, 0);
        rd(6'h38, d); chk("R1 mask", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2: address map and read-back widths
        for (int c = 0; c < 3; c++) begin
            wr(6'(16*c + 4),  32'hC0DE_0100 + c);
            wr(6'(16*c + 8),  32'hC0DE_0200 + c);
            wr(6'(16*c + 12), 32'hC0DE_0300 + c);
        end
        for (int c = 0; c < 3; c++) begin
            rd(6'(16*c + 4),  d); chk("R2 load",  d, 32'hC0DE_0100 + c);
            rd(6'(16*c + 8),  d); chk("R2 cmpA",  d, 32'hC0DE_0200 + c);
            rd(6'(16*c + 12), d); chk("R2 cmpB",  d, 32'hC0DE_0300 + c);
        end
        wr(6'h38, 32'hFFFF_FFFF);
        rd(6'h38, d); chk("R2 mask width", d, 32'h1FF);
        wr(6'h38, 32'h0);
        wr(6'h30, 32'hFFFF_F000 | 32'h6DB);
        rd(6'h30, d); chk("R2 ctrl width", d, 32'h6DB);
        wr(6'h30, 32'h0);

        // R3 R4 R5: sweep channels, directions and run lengths
        for (int c = 0; c < 3; c++) begin
            for (int up = 0; up < 2; up++) begin
                for (int n = 0; n < 6; n++) begin
                    logic [31:0] st;
                    logic [31:0] ld;
                    st = up ? 32'hFFFF_FFFC : 32'd3;
                    ld = 32'h100 + 32'(16 * c);
                    wr(6'(16*c + 4), ld);
                    wr(6'(16*c), st);
                    wr(6'h34, 32'h1FF);
                    wr(6'h30, (32'd1 << (3*c)) | (32'(up) << (9 + c)));
                    repeat (n) @(posedge clk);
                    wr(6'h30, 32'h0);
                    exp = model(st, ld, bit'(up), n + 1, wrapped);
                    rd(6'(16*c), d);
                    chk(up ? "R3 R5 up count" : "R4 R5 down count", d, exp);
                    rd(6'h34, d);
                    chk("R5 overflow flag", (d >> (3*c + 2)) & 1, 32'(wrapped));
                    repeat (3) @(posedge clk);
                    rd(6'(16*c), d);
                    chk("R3 hold when disabled", d, exp);
                end
            end
        end

        // R7: counter write overrides the step
        wr(6'h00, 32'd10);
        wr(6'h30, 32'h201);
        repeat (2) @(posedge clk);
        wr(6'h00, 32'h500);
        wr(6'h30, 32'h0);
        rd(6'h00, d); chk("R7 write over step", d, 32'h501);

        // R6: compare A and B on channel 2
        wr(6'h20, 32'h20);
        wr(6'h28, 32'h23);
        wr(6'h2C, 32'h25);
        wr(6'h34, 32'h1FF);
        wr(6'h30, 32'h840);
        repeat (2) @(posedge clk);
        wr(6'h30, 32'h0);
        rd(6'h20, d); chk("R6 count at A", d, 32'h23);
        rd(6'h34, d); chk("R6 A only", (d >> 6) & 7, 32'd1);
        wr(6'h30, 32'h840);
        repeat (1) @(posedge clk);
        wr(6'h30, 32'h0);
        rd(6'h34, d); chk("R6 B set", (d >> 6) & 7, 32'd3);

        // R9: event wins over simultaneous clear
        wr(6'h00, 32'h40);
        wr(6'h08, 32'h42);
        wr(6'h34, 32'h1FF);
        wr(6'h30, 32'h201);
        repeat (1) @(posedge clk);
        wr(6'h34, 32'h1FF);
        wr(6'h30, 32'h0);
        rd(6'h34, d); chk("R9 event beats clear", d & 1, 32'd1);
        wr(6'h34, 32'h0);
        rd(6'h34, d); chk("R9 write 0 keeps", d & 1, 32'd1);

        // R10: mask gating of a match bit
        chk("R10 irq from match", {31'd0, irq}, 1);
        wr(6'h38, 32'h1);
        #1 chk("R10 masked", {31'd0, irq}, 0);
        wr(6'h38, 32'h0);
        #1 chk("R10 unmasked", {31'd0, irq}, 1);
        wr(6'h34, 32'h1);
        rd(6'h34, d); chk("R9 write 1 clears", d, 32'h0);
        chk("R10 quiet after clear", {31'd0, irq}, 0);

        // R10: overflow needs its enable
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h30, 32'h408);
        wr(6'h30, 32'h0);
        rd(6'h34, d); chk("R5 ch1 overflow", d, 32'h20);
        chk("R10 ovf without enable", {31'd0, irq}, 0);
        wr(6'h30, 32'h20);
        #1 chk("R10 ovf with enable", {31'd0, irq}, 1);
        wr(6'h34, 32'h1FF);
        wr(6'h30, 32'h0);

        // R8: external tick on channel 1
        wr(6'h10, 32'h70);
        wr(6'h30, 32'h418);
        rd(6'h10, d);
        ext_tick[1] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); #1 chk("R8 no change after 2 edges", bus_rdata, 32'h70);
        @(posedge clk);
        @(negedge clk); #1 chk("R8 step on 3rd edge", bus_rdata, 32'h71);
        repeat (5) @(posedge clk);
        @(negedge clk); #1 chk("R8 one step per rise", bus_rdata, 32'h71);
        ext_tick[1] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) ext_tick[1] = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk); #1 chk("R8 second rise", bus_rdata, 32'h72);
        wr(6'h30, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule